// File: doc/BRIEF.md
# Next Program Counter Generator

This block owns the 12-bit program counter of a small 8-bit controller core and works out where execution goes next. Each time the core retires an instruction it raises `step` while presenting the opcode, the byte that follows it, the accumulator, the outcome of the branch condition (evaluated elsewhere) and the return address popped from the stack. On that clock edge the counter moves to the successor address.

There are several kinds of successor:
- The sequential increment steps over one or two bytes.
- A long jump or call builds an address from opcode bits and a latched bank bit.
- An in-page branch replaces only the low byte.
- An accumulator-indirect jump also replaces only the low byte.
- A return takes the stacked address.

Two one-byte table-read opcodes are also decoded. For these the block presents, without waiting for a clock edge, the program-memory address of the operand. It also offers, without waiting for a clock edge, the return address for a call and the accumulator bit index named by a bit-test branch.

Top module: `npc_gen`

## Requirements
- R1: After reset the counter is 000h and the bank bit is 0, so a long jump issued before any bank select lands with bit 11 clear.
- R2: While `step` is 0 the counter holds its value whatever the other inputs are.
- R3: The following opcodes are two bytes long:
  - low nibble 4 or 6;
  - low five bits 10010;
  - E8h-EFh, B0h-B1h and B8h-BFh;
  - 03h, 13h, 23h, 43h, 53h and D3h;
  - 88h-8Bh and 98h-9Bh.
  All other opcodes are one byte. A stepped non-branch opcode advances the counter by its length. The addition wraps within bits 10:0 and leaves bit 11 unchanged.
- R4: A stepped opcode with low nibble 4 (a jump, or a call when bit 4 is 1) loads the counter with {bank bit, opcode[7:5], second byte}.
- R5: Opcode E5h clears the bank bit and F5h sets it. Each is one byte long. The bank bit reaches the counter only through a later long jump or call, never through sequential advance.
- R6: The conditional branches are opcodes with low nibble 6, opcodes with low five bits 10010, and E8h-EFh. A stepped conditional branch with `cond_taken` = 1 loads {bits 11:8 of (PC+1 wrapped per R3), second byte}. With `cond_taken` = 0 it advances by two.
- R7: Whenever the opcode's low five bits are 10010, `test_bit_sel` equals opcode[7:5].
- R8: A stepped B3h loads {current PC[11:8], accumulator}.
- R9: A stepped 83h or 93h loads `stack_pc`.
- R10: For opcode A3h, `tbl_valid` is 1 and `tbl_addr` is {bits 11:8 of PC+1 wrapped, accumulator}. For E3h, `tbl_valid` is 1 and `tbl_addr` is {3h, accumulator}. For any other opcode `tbl_valid` is 0. Both table reads advance the counter by one.
- R11: `ret_addr` always equals the current PC plus two, wrapped as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance the counter on this edge |
| opcode | input | 8 | Opcode at the current PC |
| imm | input | 8 | Byte following the opcode |
| acc | input | 8 | Accumulator |
| cond_taken | input | 1 | Branch condition result for a conditional branch |
| stack_pc | input | 12 | Return address popped from the stack |
| pc | output | 12 | Current program counter |
| ret_addr | output | 12 | Address to push for a call |
| tbl_valid | output | 1 | Opcode is a table read |
| tbl_addr | output | 12 | Table-read operand address |
| test_bit_sel | output | 3 | Accumulator bit index for a bit-test branch |

## Verification
The counter and bank bit are registered, so a successor applied with `step` is due one clock edge later. `tbl_valid`, `tbl_addr`, `ret_addr` and `test_bit_sel` are combinational and are due in the same cycle as the inputs.

The bench drives inputs just after the falling edge. It checks the combinational outputs a moment later against a reference model holding the current PC. It checks `pc` at the next falling edge, after the model has applied the same step.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      K_SEQ  = 3'd0,
      K_LONG = 3'd1,
      K_COND = 3'd2,
      K_ACCJ = 3'd3,
      K_RET  = 3'd4,
      K_BANK = 3'd5
   } npc_kind_e;

   typedef enum logic [1:0] {
      T_NONE  = 2'd0,
      T_PAGE  = 2'd1,
      T_FIXED = 2'd2
   } npc_tbl_e;

   typedef struct packed {
      npc_kind_e kind;
      logic      two_byte;
      npc_tbl_e  tbl;
      logic      bit_test;
   } npc_dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int OP_W = 8
)(
   input  logic [OP_W-1:0] op,
   output npc_dec_t        dec
);
   if (OP_W != 8) begin : g_bad_op
      $error("npc_decode: opcode width must be 8");
   end

   logic [3:0] lo;
   logic       is_imm_alu, is_port_imm, is_mov_imm, is_djnz, is_jb;

   assign lo          = op[3:0];
   assign is_jb       = (op[4:0] == 5'b10010);
   assign is_djnz     = (op[7:3] == 5'b11101);
   assign is_imm_alu  = (lo == 4'h3) && (op[7:4] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'hD});
   assign is_port_imm = (op[7:2] == 6'b100010) || (op[7:2] == 6'b100110);
   assign is_mov_imm  = (op[7:1] == 7'b1011000) || (op[7:3] == 5'b10111);

   always_comb begin
      dec          = '0;
      dec.kind     = K_SEQ;
      dec.tbl      = T_NONE;
      dec.bit_test = is_jb;
      if (lo == 4'h4)                          dec.kind = K_LONG;
      else if (lo == 4'h6 || is_jb || is_djnz) dec.kind = K_COND;
      else if (op == 8'hB3)                    dec.kind = K_ACCJ;
      else if (op == 8'h83 || op == 8'h93)     dec.kind = K_RET;
      else if (op == 8'hE5 || op == 8'hF5)     dec.kind = K_BANK;
      dec.two_byte = (lo == 4'h4) || (lo == 4'h6) || is_jb || is_djnz ||
                     is_imm_alu || is_port_imm || is_mov_imm;
      if (op == 8'hA3)      dec.tbl = T_PAGE;
      else if (op == 8'hE3) dec.tbl = T_FIXED;
   end
endmodule

// File: rtl/npc_incr.sv
module npc_incr #(
   parameter int PC_W   = 12,
   parameter int STEP   = 1,
   parameter bit RIPPLE = 1'b0
)(
   input  logic [PC_W-1:0] a,
   output logic [PC_W-1:0] y
);
   localparam int LOW_W = PC_W - 1;

   if (STEP < 1 || STEP > 3) begin : g_bad_step
      $error("npc_incr: STEP out of range");
   end

   localparam logic [LOW_W-1:0] K = LOW_W'(STEP);
   logic [LOW_W-1:0] sum;

   if (RIPPLE) begin : g_ripple
      logic [LOW_W:0] c;
      assign c[0] = 1'b0;
      for (genvar i = 0; i < LOW_W; i++) begin : g_bit
         assign sum[i]   = a[i] ^ K[i] ^ c[i];
         assign c[i+1]   = (a[i] & K[i]) | (c[i] & (a[i] ^ K[i]));
      end
   end else begin : g_adder
      assign sum = a[LOW_W-1:0] + K;
   end

   // top bit is never touched by sequential advance
   assign y = {a[PC_W-1], sum};
endmodule

// File: rtl/npc_bank.sv
module npc_bank #(
   parameter int OP_W = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [OP_W-1:0] op,
   output logic            bank
);
   always_ff @(posedge clk) begin
      if (!rst_n)    bank <= 1'b0;
      else if (load) bank <= op[4];
   end

   a_r5_bank_value: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bank == $past(op[4])));
endmodule

// File: rtl/npc_gen.sv
module npc_gen
   import npc_pkg::*;
#(
   parameter int          PC_W           = 12,
   parameter int          DATA_W         = 8,
   parameter logic [3:0]  TBL_FIXED_PAGE = 4'h3,
   parameter bit          RIPPLE_INC     = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [DATA_W-1:0] opcode,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] acc,
   input  logic              cond_taken,
   input  logic [PC_W-1:0]   stack_pc,
   output logic [PC_W-1:0]   pc,
   output logic [PC_W-1:0]   ret_addr,
   output logic              tbl_valid,
   output logic [PC_W-1:0]   tbl_addr,
   output logic [2:0]        test_bit_sel
);
   localparam int PAGE_W = PC_W - DATA_W;
   localparam int LJ_W   = PC_W - 1 - DATA_W;

   if (PC_W != DATA_W + 4) begin : g_bad_width
      $error("npc_gen: PC_W must be DATA_W + 4");
   end
   if (LJ_W != 3) begin : g_bad_long
      $error("npc_gen: long target field must be 3 bits");
   end

   npc_dec_t        dec;
   logic            bank;
   logic [PC_W-1:0] pc_q, pc_d, pc_p1, pc_p2;

   npc_decode #(.OP_W(DATA_W)) u_dec (.op(opcode), .dec(dec));

   npc_incr #(.PC_W(PC_W), .STEP(1), .RIPPLE(RIPPLE_INC)) u_inc1 (.a(pc_q), .y(pc_p1));
   npc_incr #(.PC_W(PC_W), .STEP(2), .RIPPLE(RIPPLE_INC)) u_inc2 (.a(pc_q), .y(pc_p2));

   npc_bank #(.OP_W(DATA_W)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .load (step && dec.kind == K_BANK),
      .op   (opcode),
      .bank (bank)
   );

   always_comb begin
      unique case (dec.kind)
         K_LONG:  pc_d = {bank, opcode[DATA_W-1 -: LJ_W], imm};
         K_COND:  pc_d = cond_taken ? {pc_p1[PC_W-1 -: PAGE_W], imm} : pc_p2;
         K_ACCJ:  pc_d = {pc_q[PC_W-1 -: PAGE_W], acc};
         K_RET:   pc_d = stack_pc;
         default: pc_d = dec.two_byte ? pc_p2 : pc_p1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pc_q <= '0;
      else if (step) pc_q <= pc_d;
   end

   always_comb begin
      tbl_valid = (dec.tbl != T_NONE);
      tbl_addr  = '0;
      if (dec.tbl == T_PAGE)       tbl_addr = {pc_p1[PC_W-1 -: PAGE_W], acc};
      else if (dec.tbl == T_FIXED) tbl_addr = {TBL_FIXED_PAGE, acc};
   end

   assign pc           = pc_q;
   assign ret_addr     = pc_p2;
   assign test_bit_sel = dec.bit_test ? opcode[7:5] : 3'd0;

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pc_q));
   a_r4_long_target: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dec.kind == K_LONG) |=>
         (pc_q == {$past(bank), $past(opcode[7:5]), $past(imm)}));
   a_r3_seq_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (dec.kind == K_SEQ || dec.kind == K_BANK)) |=>
         (pc_q[PC_W-1] == $past(pc_q[PC_W-1])));
   a_r8_acc_jump: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dec.kind == K_ACCJ) |=>
         (pc_q == {$past(pc_q[PC_W-1 -: PAGE_W]), $past(acc)}));
   a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dec.kind == K_RET) |=> (pc_q == $past(stack_pc)));
   a_r6_taken_low: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dec.kind == K_COND && cond_taken) |=>
         (pc_q[DATA_W-1:0] == $past(imm)));
   a_r10_fixed_page: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.tbl == T_FIXED) |-> (tbl_valid && tbl_addr[PC_W-1 -: PAGE_W] == TBL_FIXED_PAGE));
endmodule

// File: tb/tb_npc_gen.sv
module tb_npc_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [7:0]  opcode = 8'h00, imm = 8'h00, acc = 8'h00;
   logic        cond_taken = 1'b0;
   logic [11:0] stack_pc = 12'h000;
   logic [11:0] pc, ret_addr, tbl_addr;
   logic        tbl_valid;
   logic [2:0]  test_bit_sel;

   int vectors = 0;
   int fails   = 0;
   int m_pc    = 0;
   int m_bank  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_gen dut (
      .clk(clk), .rst_n(rst_n), .step(step), .opcode(opcode), .imm(imm),
      .acc(acc), .cond_taken(cond_taken), .stack_pc(stack_pc), .pc(pc),
      .ret_addr(ret_addr), .tbl_valid(tbl_valid), .tbl_addr(tbl_addr),
      .test_bit_sel(test_bit_sel)
   );

   function automatic int wrap_add(int p, int n);
      return (p & 'h800) | ((p + n) & 'h7FF);
   endfunction

   function automatic int op_len(logic [7:0] o);
      if (o[3:0] == 4'h4 || o[3:0] == 4'h6) return 2;
      if (o[4:0] == 5'b10010) return 2;
      if (o >= 8'hE8 && o <= 8'hEF) return 2;
      if (o == 8'hB0 || o == 8'hB1 || (o >= 8'hB8 && o <= 8'hBF)) return 2;
      if (o == 8'h03 || o == 8'h13 || o == 8'h23 || o == 8'h43 || o == 8'h53 || o == 8'hD3) return 2;
      if ((o >= 8'h88 && o <= 8'h8B) || (o >= 8'h98 && o <= 8'h9B)) return 2;
      return 1;
   endfunction

   function automatic bit is_cond(logic [7:0] o);
      return (o[3:0] == 4'h6) || (o[4:0] == 5'b10010) || (o >= 8'hE8 && o <= 8'hEF);
   endfunction

   task automatic check(string req, int got, int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %03h expected %03h", req, got, exp);
      end
   endtask

   // one vector: check pc against model, drive inputs, check combinational outputs, advance model
   task automatic apply(logic [7:0] o, logic [7:0] b, logic [7:0] a, logic c,
                        logic [11:0] s, logic st);
      string req;
      @(negedge clk);
      check("R2/R3..R9 pc", int'(pc), m_pc);
      opcode = o; imm = b; acc = a; cond_taken = c; stack_pc = s; step = st;
      #1;
      check("R11 ret_addr", int'(ret_addr), wrap_add(m_pc, 2));
      if (o == 8'hA3) begin
         check("R10 tbl_valid", int'(tbl_valid), 1);
         check("R10 tbl_addr page", int'(tbl_addr), (wrap_add(m_pc, 1) & 'hF00) | a);
      end else if (o == 8'hE3) begin
         check("R10 tbl_valid", int'(tbl_valid), 1);
         check("R10 tbl_addr fixed", int'(tbl_addr), 'h300 | a);
      end else
         check("R10 tbl_valid low", int'(tbl_valid), 0);
      if (o[4:0] == 5'b10010) check("R7 test_bit_sel", int'(test_bit_sel), int'(o[7:5]));
      if (st) begin
         if (o[3:0] == 4'h4)              m_pc = (m_bank << 11) | (int'(o[7:5]) << 8) | b;
         else if (is_cond(o))             m_pc = c ? ((wrap_add(m_pc, 1) & 'hF00) | b) : wrap_add(m_pc, 2);
         else if (o == 8'hB3)             m_pc = (m_pc & 'hF00) | a;
         else if (o == 8'h83 || o == 8'h93) m_pc = int'(s);
         else begin
            if (o == 8'hE5) m_bank = 0;
            if (o == 8'hF5) m_bank = 1;
            m_pc = wrap_add(m_pc, op_len(o));
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset pc", int'(pc), 0);
      // R1: jump before any bank select keeps bit 11 clear
      apply(8'hE4, 8'h55, 8'h00, 0, 12'h0, 1);
      @(negedge clk); check("R1 bank clear after reset", int'(pc), 'h755);
      // R2: hold while step low, with branch-like inputs
      apply(8'h83, 8'h00, 8'h00, 1, 12'hABC, 0);
      apply(8'h04, 8'h11, 8'h00, 1, 12'h123, 0);
      // R3: one- and two-byte advance
      apply(8'h00, 8'h00, 8'h00, 0, 12'h0, 1);
      apply(8'h23, 8'h9A, 8'h00, 0, 12'h0, 1);
      apply(8'hB9, 8'h01, 8'h00, 0, 12'h0, 1);
      // R5: set bank, sequential unaffected, then long jump to top
      apply(8'hF5, 8'h00, 8'h00, 0, 12'h0, 1);
      apply(8'h00, 8'h00, 8'h00, 0, 12'h0, 1);
      apply(8'hE4, 8'hFF, 8'h00, 0, 12'h0, 1);   // R4 -> FFF
      apply(8'h00, 8'h00, 8'h00, 0, 12'h0, 1);   // R3 wrap to 800
      apply(8'h94, 8'hFE, 8'h00, 0, 12'h0, 1);   // R4 call -> CFE
      apply(8'h00, 8'h00, 8'h00, 0, 12'h0, 1);   // CFF
      apply(8'h00, 8'h00, 8'h00, 0, 12'h0, 1);   // D00
      apply(8'h04, 8'hFF, 8'h00, 0, 12'h0, 1);   // 8FF
      // R6: taken branch at page end uses page of next byte
      apply(8'hC6, 8'h20, 8'h00, 1, 12'h0, 1);   // -> 920
      apply(8'hE4, 8'hFF, 8'h00, 0, 12'h0, 1);   // FFF
      apply(8'hF6, 8'h10, 8'h00, 1, 12'h0, 1);   // wrap page -> 810
      apply(8'hE9, 8'h44, 8'h00, 0, 12'h0, 1);   // not taken -> 812
      apply(8'hB2, 8'h77, 8'h00, 1, 12'h0, 1);   // R7 bit-test taken
      // R5: clear bank, sequential keeps bit 11, next jump clears it
      apply(8'hE5, 8'h00, 8'h00, 0, 12'h0, 1);
      apply(8'h00, 8'h00, 8'h00, 0, 12'h0, 1);
      apply(8'h24, 8'h80, 8'h00, 0, 12'h0, 1);
      // R8 and R10
      apply(8'hB3, 8'h00, 8'h3C, 0, 12'h0, 1);
      apply(8'hA3, 8'h00, 8'h5A, 0, 12'h0, 1);
      apply(8'hE3, 8'h00, 8'hC3, 0, 12'h0, 1);
      apply(8'h04, 8'hFF, 8'h00, 0, 12'h0, 1);
      apply(8'hA3, 8'h00, 8'h01, 0, 12'h0, 0);   // table at page end
      // R9
      apply(8'h93, 8'h00, 8'h00, 0, 12'hA5A, 1);
      apply(8'h83, 8'h00, 8'h00, 0, 12'h3C3, 1);
      // random mix
      for (int i = 0; i < 3000; i++)
         apply(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
               12'($urandom), ($urandom % 4) != 0);
      @(negedge clk);
      check("final pc", int'(pc), m_pc);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule